// File: doc/BRIEF.md
# SPI Wiper and Control Register Slave

This block is the digital side of a single-channel digital potentiometer. It holds two volatile registers behind a four-wire SPI slave: a 7-bit wiper position and a small control register. A host writes the wiper code and the control bits with 16-bit frames, and reads either register back. The wiper code and a shutdown flag leave the block as plain digital outputs that feed the tap decoder of the resistor ladder. The ladder itself is not part of the block.

All logic runs on a system clock `clk`, which must be much faster than the serial clock. The inputs `sck`, `cs_n` and `sdi` pass through a synchronizer of `SYNC_STAGES` flops, and edge pulses are derived from it. A frame state machine has four states. `ST_IDLE` means deselected or not yet armed. `ST_CMD` receives the command byte. `ST_DATA` receives write data or shifts out read data. `ST_DONE` means the frame is complete and the block waits for deselect. The transitions are: IDLE to CMD on a falling chip select; CMD to DATA on the 8th rising SCK; DATA to DONE on the 16th rising SCK; and any state to IDLE on a rising chip select.

A frame is sent MSB first. The command byte has bit 7 as the direction (1 = read, 0 = write), bits 6:5 ignored, and bits 4:0 as the register address. The second byte is the write data, or the slot in which the read data is shifted out. The wiper register sits at address 00h and the control register at address 10h. In the control register, bit 6 is shutdown-disable and bit 1 selects an open-drain serial output.

Top module: `spi_pot_regif`

## Requirements
- R1: After reset, `wiper_code` is 40h, `shutdown` is 0, the control register reads 40h, and `sdo_oe` is 0.
- R2: A frame is 16 `sdi` bits sampled on rising `sck` while `cs_n` is low, MSB first. Command bit 7 = 1 means read and 0 means write. Bits 4:0 are the address and bits 6:5 are ignored.
- R3: A write to address 00h stores data bits 6:0 in the wiper. A read of address 00h returns bit 7 as 0 and bits 6:0 as the wiper. `wiper_code` changes only on a completed write frame.
- R4: A write to address 10h stores only bit 6 (shutdown-disable) and bit 1 (open-drain select). Every other bit reads back as 0. `shutdown` equals the inverse of bit 6.
- R5: A write to any address other than 00h and 10h changes nothing. A read from such an address returns 00h.
- R6: In a read frame, the output changes on falling `sck` edges. Data bit 7 is presented after the falling edge that follows the 8th rising edge, then bits 6 to 0 in turn. `sdo_oe` is 0 during the command byte and during every write frame.
- R7: A rising `cs_n` releases `sdo_oe` and returns the block to `ST_IDLE`. A frame cut short before its 16th rising edge changes no register.
- R8: After reset, bits clocked in are ignored until `cs_n` has gone from high to low once.
- R9: In open-drain mode (control bit 1 = 1), `sdo_o` is 0 and `sdo_oe` is high only while a 0 bit is presented. The line therefore only pulls low.
- R10: In push-pull mode (control bit 1 = 0), `sdo_oe` is 1 throughout the read data slot and `sdo_o` carries the data bit.
- R11: Once 16 bits have arrived, further `sck` cycles before `cs_n` rises are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than `sck` |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial output data value |
| sdo_oe | output | 1 | Serial output drive enable (line is released when 0) |
| wiper_code | output | 7 | Wiper tap code, 00h low end to 7Fh high end |
| shutdown | output | 1 | 1 opens the ladder and parks the wiper at the low end |

## Verification
The properties assume that the host holds `sdi` steady around each rising `sck`, and that `sck` and `cs_n` stay in each level for several `clk` cycles. Under these conditions every serial edge is seen exactly once after the synchronizer. They also assume that `sck` is low when `cs_n` changes. The bench meets these conditions by driving every serial signal on the falling edge of `clk`, with eight `clk` cycles per half period of `sck`. It changes `cs_n` only while `sck` is idle low. It samples the line just before each rising `sck`, and it treats a released line as pulled high.

// File: rtl/spi_pot_pkg.sv
package spi_pot_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned ADDR_W     = 5;
    localparam int unsigned WIPER_W    = 7;
    localparam int unsigned FRAME_BITS = 2 * BYTE_W;

    localparam logic [ADDR_W-1:0]  ADDR_WIPER = 5'h00;
    localparam logic [ADDR_W-1:0]  ADDR_CTRL  = 5'h10;
    localparam int unsigned        CTRL_SDN_BIT = 6;
    localparam int unsigned        CTRL_OD_BIT  = 1;
    localparam logic [BYTE_W-1:0]  CTRL_MASK  = 8'h42;
    localparam logic [BYTE_W-1:0]  CTRL_RST   = 8'h40;
    localparam logic [WIPER_W-1:0] WIPER_RST  = 7'h40;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_DONE
    } fr_state_e;
endpackage

// File: rtl/spi_pot_sync.sv
module spi_pot_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic sdi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic sdi_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] sdi_p;

    // chip select history resets low so a select held low through reset is no falling edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= '0;
            cs_p  <= '0;
        end else begin
            sck_p <= {sck_p[STAGES-1:0], sck};
            cs_p  <= {cs_p[STAGES-1:0], cs_n};
        end
    end

    generate
        if (STAGES > 1) begin : g_sdi_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sdi_p <= '0;
                else        sdi_p <= {sdi_p[STAGES-2:0], sdi};
            end
        end else begin : g_sdi_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sdi_p <= '0;
                else        sdi_p <= sdi;
            end
        end
    endgenerate

    always_comb begin
        sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
        sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
        cs_fall  = ~cs_p[STAGES-1] & cs_p[STAGES];
        cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
        sdi_s    = sdi_p[STAGES-1];
    end
endmodule

// File: rtl/spi_pot_frame.sv
module spi_pot_frame
    import spi_pot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sck_rise,
    input  logic                sck_fall,
    input  logic                cs_fall,
    input  logic                cs_rise,
    input  logic                sdi_s,
    input  logic [BYTE_W-1:0]   rd_data,
    output fr_state_e           state,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [BYTE_W-1:0]   wr_data,
    output logic                wr_commit,
    output logic                tx_active,
    output logic                tx_bit
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

    fr_state_e          state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  shift_in;
    logic               cmd_rd;
    logic [ADDR_W-1:0]  cmd_addr;
    logic [BYTE_W-2:0]  tx_sr;
    logic               tx_on;
    logic               tx_q;
    logic               last_rise;

    assign last_rise = sck_rise && (bit_cnt == LAST_BIT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cs_fall) state_d = ST_CMD;
            ST_CMD: begin
                if (cs_rise) state_d = ST_IDLE;
                else if (sck_rise && bit_cnt == LAST_CMD) state_d = ST_DATA;
            end
            ST_DATA: begin
                if (cs_rise) state_d = ST_IDLE;
                else if (last_rise) state_d = ST_DONE;
            end
            ST_DONE: if (cs_rise) state_d = ST_IDLE;
        endcase
    end

    // receive and transmit datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shift_in <= '0;
            cmd_rd   <= 1'b0;
            cmd_addr <= '0;
            tx_sr    <= '0;
            tx_on    <= 1'b0;
            tx_q     <= 1'b0;
        end else begin
            if (state_q == ST_IDLE) begin
                bit_cnt <= '0;
            end else if (sck_rise && (state_q == ST_CMD || state_q == ST_DATA)) begin
                shift_in <= {shift_in[BYTE_W-2:0], sdi_s};
                bit_cnt  <= bit_cnt + CNT_W'(1);
                if (state_q == ST_CMD && bit_cnt == LAST_CMD) begin
                    cmd_rd   <= shift_in[BYTE_W-2];
                    cmd_addr <= {shift_in[ADDR_W-2:0], sdi_s};
                end
            end

            if (cs_rise || state_q != ST_DATA || last_rise) begin
                tx_on <= 1'b0;
                tx_q  <= 1'b0;
            end else if (sck_fall && cmd_rd) begin
                if (!tx_on) begin
                    tx_on <= 1'b1;
                    tx_q  <= rd_data[BYTE_W-1];
                    tx_sr <= rd_data[BYTE_W-2:0];
                end else begin
                    tx_q  <= tx_sr[BYTE_W-2];
                    tx_sr <= {tx_sr[BYTE_W-3:0], 1'b0};
                end
            end
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        reg_addr  = cmd_addr;
        wr_data   = {shift_in[BYTE_W-2:0], sdi_s};
        wr_commit = (state_q == ST_DATA) && last_rise && !cmd_rd && !cs_rise;
        tx_active = tx_on;
        tx_bit    = tx_q;
    end
endmodule

// File: rtl/spi_pot_regfile.sv
module spi_pot_regfile
    import spi_pot_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                wr_en,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   rd_data,
    output logic [WIPER_W-1:0]  wiper_code,
    output logic                ctrl_sdn,
    output logic                ctrl_od
);
    logic [WIPER_W-1:0] wiper_q;
    logic [BYTE_W-1:0]  ctrl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wiper_q <= WIPER_RST;
            ctrl_q  <= CTRL_RST;
        end else if (wr_en) begin
            if (addr == ADDR_WIPER) wiper_q <= wr_data[WIPER_W-1:0];
            if (addr == ADDR_CTRL)  ctrl_q  <= wr_data & CTRL_MASK;
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_WIPER: rd_data = {{(BYTE_W-WIPER_W){1'b0}}, wiper_q};
            ADDR_CTRL:  rd_data = ctrl_q;
            default:    rd_data = '0;
        endcase
        wiper_code = wiper_q;
        ctrl_sdn   = ctrl_q[CTRL_SDN_BIT];
        ctrl_od    = ctrl_q[CTRL_OD_BIT];
    end
endmodule

// File: rtl/spi_pot_regif.sv
module spi_pot_regif
    import spi_pot_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck,
    input  logic               cs_n,
    input  logic               sdi,
    output logic               sdo_o,
    output logic               sdo_oe,
    output logic [WIPER_W-1:0] wiper_code,
    output logic               shutdown
);
    logic              sck_rise, sck_fall, cs_fall, cs_rise, sdi_s;
    fr_state_e         fr_state;
    logic [ADDR_W-1:0] reg_addr;
    logic [BYTE_W-1:0] wr_data, rd_data;
    logic              wr_commit, tx_active, tx_bit;
    logic              ctrl_sdn, ctrl_od;

    spi_pot_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sdi      (sdi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .sdi_s    (sdi_s)
    );

    spi_pot_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .cs_fall   (cs_fall),
        .cs_rise   (cs_rise),
        .sdi_s     (sdi_s),
        .rd_data   (rd_data),
        .state     (fr_state),
        .reg_addr  (reg_addr),
        .wr_data   (wr_data),
        .wr_commit (wr_commit),
        .tx_active (tx_active),
        .tx_bit    (tx_bit)
    );

    spi_pot_regfile u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr_en      (wr_commit),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .wiper_code (wiper_code),
        .ctrl_sdn   (ctrl_sdn),
        .ctrl_od    (ctrl_od)
    );

    // output driver: open-drain only ever sinks, push-pull drives the bit
    always_comb begin
        if (ctrl_od) begin
            sdo_o  = 1'b0;
            sdo_oe = tx_active & ~tx_bit;
        end else begin
            sdo_o  = tx_active & tx_bit;
            sdo_oe = tx_active;
        end
        shutdown = ~ctrl_sdn;
    end
endmodule

// File: rtl/spi_pot_chk.sv
module spi_pot_chk
    import spi_pot_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               sdo_o,
    input logic               sdo_oe,
    input logic [WIPER_W-1:0] wiper_code,
    input logic               shutdown,
    input logic               ctrl_od,
    input fr_state_e          st,
    input logic               wr_commit,
    input logic               cs_rise
);
    // R9: open-drain never drives a one
    p_od_sink_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_od && sdo_oe) |-> !sdo_o);

    // R3: wiper moves only on a committed write
    p_wiper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(wiper_code));

    // R4: shutdown moves only on a committed write
    p_shdn_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_commit |=> $stable(shutdown));

    // R6: output enabled only inside the data slot
    p_oe_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (st == ST_DATA));

    // R7: deselect returns the frame machine to idle
    p_deselect_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rise |=> (st == ST_IDLE && !sdo_oe));
endmodule

bind spi_pot_regif spi_pot_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sdo_o      (sdo_o),
    .sdo_oe     (sdo_oe),
    .wiper_code (wiper_code),
    .shutdown   (shutdown),
    .ctrl_od    (ctrl_od),
    .st         (fr_state),
    .wr_commit  (wr_commit),
    .cs_rise    (cs_rise)
);

// File: tb/test_spi_pot_regif.sv
module test_spi_pot_regif;
    localparam int H = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       cs_n = 1'b0;
    logic       sdi = 1'b0;
    logic       sdo_o, sdo_oe, shutdown;
    logic [6:0] wiper_code;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    typedef struct { logic [7:0] val; string req; } exp_t;
    exp_t       exp_q[$];
    logic [7:0] obs_q[$];

    always #10 clk = ~clk;

    spi_pot_regif i_spi_pot_regif (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi),
        .sdo_o(sdo_o), .sdo_oe(sdo_oe), .wiper_code(wiper_code), .shutdown(shutdown)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // drives one frame; returns the byte seen on the line in the data slot
    task automatic xfer(input logic [23:0] bits, input int nbits, input bit toggle,
                        output logic [7:0] rx, output bit oe_cmd, output bit od_hi);
        logic line;
        rx = '0; oe_cmd = 1'b0; od_hi = 1'b0;
        if (toggle) begin
            cs_n = 1'b1; wait_clk(H);
            cs_n = 1'b0; wait_clk(H);
        end
        for (int i = 0; i < nbits; i++) begin
            sdi = bits[23-i];
            wait_clk(H);
            line = sdo_oe ? sdo_o : 1'b1;
            if (i < 8 && sdo_oe) oe_cmd = 1'b1;
            if (sdo_oe && sdo_o) od_hi = 1'b1;
            if (i >= 8 && i < 16) rx = {rx[6:0], line};
            sck = 1'b1; wait_clk(H);
            sck = 1'b0;
        end
        wait_clk(H);
        if (toggle) cs_n = 1'b1;
        wait_clk(H);
    endtask

    task automatic wr(input logic [7:0] cmd, input logic [7:0] data);
        logic [7:0] rx; bit a, b;
        xfer({cmd, data, 8'h00}, 16, 1'b1, rx, a, b);
        check("R6 no drive in write frame", {7'd0, a}, 8'h00);
    endtask

    // driver: pushes the expected byte, then hands the observed byte to the monitor
    task automatic rd(input logic [7:0] cmd, input logic [7:0] exp, input string req);
        logic [7:0] rx; bit a, b;
        exp_q.push_back('{exp, req});
        xfer({cmd, 8'h00, 8'h00}, 16, 1'b1, rx, a, b);
        obs_q.push_back(rx);
        check("R6 no drive in command byte", {7'd0, a}, 8'h00);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (obs_q.size() > 0 && exp_q.size() > 0) begin
                exp_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                check(e.req, o, e.val);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rx; bit a, od_hi;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);
        check("R1 wiper reset", {1'b0, wiper_code}, 8'h40);
        check("R1 shutdown reset", {7'd0, shutdown}, 8'h00);
        check("R1 oe reset", {7'd0, sdo_oe}, 8'h00);

        // R8: select held low since reset, bits must be ignored
        xfer({8'h00, 8'h05, 8'h00}, 16, 1'b0, rx, a, od_hi);
        check("R8 no frame before select edge", {1'b0, wiper_code}, 8'h40);
        cs_n = 1'b1; wait_clk(H);

        rd(8'h80, 8'h40, "R3 R10 read wiper reset");
        rd(8'h90, 8'h40, "R1 read control reset");

        wr(8'h00, 8'h7F);
        check("R3 wiper top", {1'b0, wiper_code}, 8'h7F);
        wr(8'h00, 8'hFF);
        rd(8'h80, 8'h7F, "R3 bit7 reads zero");
        wr(8'h00, 8'h00);
        check("R3 wiper bottom", {1'b0, wiper_code}, 8'h00);
        wr(8'h00, 8'h5A);
        rd(8'h80, 8'h5A, "R2 R6 read pattern msb first");

        wr(8'h10, 8'h00);
        check("R4 shutdown asserted", {7'd0, shutdown}, 8'h01);
        rd(8'h90, 8'h00, "R4 control cleared");
        wr(8'h10, 8'hFF);
        check("R4 shutdown released", {7'd0, shutdown}, 8'h00);
        rd(8'h90, 8'h42, "R4 only bits 6 and 1 stored");

        // R9: open-drain read of a mixed pattern
        exp_q.push_back('{8'h5A, "R9 open-drain read"});
        xfer({8'h80, 8'h00, 8'h00}, 16, 1'b1, rx, a, od_hi);
        obs_q.push_back(rx);
        check("R9 open-drain never drives high", {7'd0, od_hi}, 8'h00);
        wr(8'h10, 8'h40);

        // R2: bits 6:5 of the command ignored
        wr(8'h60, 8'h22);
        check("R2 address bits only", {1'b0, wiper_code}, 8'h22);
        rd(8'hE0, 8'h22, "R2 read with high bits set");

        // R5: unmapped addresses
        wr(8'h05, 8'h00);
        wr(8'h11, 8'h00);
        rd(8'h80, 8'h22, "R5 wiper untouched");
        rd(8'h90, 8'h40, "R5 control untouched");
        rd(8'h9F, 8'h00, "R5 unmapped read");

        // R7: aborted frames
        xfer({8'h00, 8'h33, 8'h00}, 12, 1'b1, rx, a, od_hi);
        check("R7 partial write 12 bits", {1'b0, wiper_code}, 8'h22);
        xfer({8'h00, 8'h33, 8'h00}, 15, 1'b1, rx, a, od_hi);
        check("R7 partial write 15 bits", {1'b0, wiper_code}, 8'h22);
        xfer({8'h10, 8'h00, 8'h00}, 15, 1'b1, rx, a, od_hi);
        check("R7 partial control write", {7'd0, shutdown}, 8'h00);
        xfer({8'h80, 8'h00, 8'h00}, 12, 1'b1, rx, a, od_hi);
        check("R7 oe released after abort", {7'd0, sdo_oe}, 8'h00);

        // R11: extra clocks after a full frame
        xfer({8'h00, 8'h11, 8'hAB}, 20, 1'b1, rx, a, od_hi);
        check("R11 trailing bits ignored", {1'b0, wiper_code}, 8'h11);
        rd(8'h80, 8'h11, "R11 read after long frame");

        wait_clk(20);
        check("scoreboard drained", 8'(exp_q.size()), 8'h00);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end
endmodule